// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers the interrupt requests of a system bridge into two CPU interrupt lines. Ninety-six sources are numbered in three groups. Sources 0 to 31 sit in a low main cause word and sources 32 to 63 sit in a high main cause word. Sources 64 to 95 are 32 general-purpose pins. The on-chip units drive level request lines. The main cause words show those lines live, filtered to the bit positions that are allowed to assert.

The pin interrupts live in a secondary bank. That bank has its own cause word and its own enable word. A pin cause is captured on a rising edge of the synchronised pin and stays set until software clears it. Software clears a bit by writing a zero to its position. The enabled pin causes are folded, eight pins at a time, into four summary bits of the high main word.

CPU0 has an enable word for each main word. CPU1 has an enable word for the low main word only, so it can be given the doorbell source (low bit 28) alone. Both interrupt outputs are registered. Registers are reached over a flat bus: a write takes effect at the clock edge, and a read returns data in the same cycle.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every enable word (pin, CPU0 low, CPU0 high, CPU1 low) reads zero, the pin cause word reads zero and both CPU interrupt outputs are low.
- R2: The main cause words follow the request lines with no latching. Only low-word bits in 0x3DFFFFFE and high-word bits in 0x1F0003F7 can read as one. A request on any other position reads zero and never raises a CPU output.
- R3: High-word bits 24 to 27 are pin summaries: bit 24+k is the OR of enabled pin causes 8k to 8k+7. Request lines at those four positions are ignored.
- R4: A pin cause bit is set by a rising edge of its pin after a two-stage synchroniser and an edge detector. It reads as set three clock edges after the pin rises, and it stays set after the pin falls. A pin held high does not set the bit again.
- R5: Writing the pin cause word (address 2) clears each bit written as zero and leaves each bit written as one unchanged.
- R6: If a pin edge and a clearing write hit the same pin cause bit in the same cycle, the bit ends set.
- R7: A pin cause reaches the summary bits only while its bit in the pin enable word (address 3) is one.
- R8: The CPU0 output (cpu_irq bit 0) is the OR of low cause AND CPU0 low enable (address 4) and high cause AND CPU0 high enable (address 5). It is registered, so it changes one clock edge after the cause or the enable changes.
- R9: The CPU1 output (cpu_irq bit 1) is the registered OR of low cause AND CPU1 low enable (address 6). The high word never reaches it.
- R10: Register map: 0 low cause, 1 high cause, 2 pin cause, 3 pin enable, 4 to 6 the CPU enables, 7 reads zero. Reads need no wait state. Writes to addresses 0, 1 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unit_req_lo | input | 32 | Level requests for sources 0 to 31 |
| unit_req_hi | input | 32 | Level requests for sources 32 to 63 |
| pin_in | input | 32 | Asynchronous general-purpose pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| cpu_irq | output | 2 | Registered interrupt lines, bit 0 for CPU0 and bit 1 for CPU1 |

## Verification
The bench clears a pin cause in exactly the cycle its edge arrives. A design that lets the clear win would lose that interrupt, and the pin cause would read zero. It writes the inverse of a one-hot value while other pins are still held high. A design that treats level as a set, or clears whole words, would keep the cleared bit or drop its neighbours. It drives requests on positions outside the valid sets and on the summary positions with pin enables off. A design that does not filter them would show bits in the cause words or raise CPU0. It also times CPU0 one edge after a change and drives high-word causes with the CPU1 enable all ones. A combinational output or a CPU1 path that leaks the high word would then be seen.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned REG_ADDR_W = 3;
  localparam int unsigned NUM_CPUS   = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_MAIN_LO   = 3'd0,
    RA_MAIN_HI   = 3'd1,
    RA_PIN_CAUSE = 3'd2,
    RA_PIN_MASK  = 3'd3,
    RA_CPU0_LO   = 3'd4,
    RA_CPU0_HI   = 3'd5,
    RA_CPU1_LO   = 3'd6,
    RA_SPARE     = 3'd7
  } reg_addr_e;

  localparam logic [WORD_W-1:0] LO_VALID_DEF = 32'h3DFF_FFFE;
  localparam logic [WORD_W-1:0] HI_VALID_DEF = 32'h1F00_03F7;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_pin_bank.sv
module irq_pin_bank #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned PIN_GROUP   = 8,
  parameter int unsigned NUM_GROUPS  = NUM_PINS / PIN_GROUP,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  wr_cause,
  input  logic                  wr_mask,
  input  logic [NUM_PINS-1:0]   wdata,
  output logic [NUM_PINS-1:0]   cause,
  output logic [NUM_PINS-1:0]   mask,
  output logic [NUM_PINS-1:0]   prev_level,
  output logic [NUM_GROUPS-1:0] summary
);

  // synchroniser stages, one register process per stage
  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [NUM_PINS-1:0] stage_nxt;
    if (s == 0) begin : g_first
      assign stage_nxt = pin_in;
    end else begin : g_later
      assign stage_nxt = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_nxt;
      end
    end
  end

  logic [NUM_PINS-1:0] level;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] cause_q;
  logic [NUM_PINS-1:0] cause_nxt;
  logic                cause_en;
  logic [NUM_PINS-1:0] mask_q;

  assign level = stage_q[SYNC_STAGES-1];
  assign rise  = level & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= level;
    end
  end

  // zero-written bits clear, a fresh edge sets and wins over the clear
  always_comb begin
    cause_nxt = cause_q;
    if (wr_cause) begin
      cause_nxt = cause_q & wdata;
    end
    cause_nxt = cause_nxt | rise;
    cause_en  = wr_cause | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sum
    assign summary[g] = |(cause_q[g*PIN_GROUP +: PIN_GROUP] & mask_q[g*PIN_GROUP +: PIN_GROUP]);
  end

  assign cause      = cause_q;
  assign mask       = mask_q;
  assign prev_level = prev_q;

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int unsigned WORD_W = 32,
  parameter bit          HAS_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] cause_lo,
  input  logic [WORD_W-1:0] cause_hi,
  output logic [WORD_W-1:0] mask_lo,
  output logic [WORD_W-1:0] mask_hi,
  output logic              irq
);

  logic [WORD_W-1:0] mask_lo_q;
  logic              irq_q;
  logic              irq_nxt;
  logic              hi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_lo_q <= '0;
    end else if (wr_lo) begin
      mask_lo_q <= wdata;
    end
  end

  if (HAS_HI) begin : g_hi
    logic [WORD_W-1:0] mask_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_hi_q <= '0;
      end else if (wr_hi) begin
        mask_hi_q <= wdata;
      end
    end
    assign mask_hi = mask_hi_q;
    assign hi_hit  = |(cause_hi & mask_hi_q);
  end else begin : g_no_hi
    logic unused_hi;
    assign unused_hi = wr_hi ^ (|cause_hi);
    assign mask_hi   = '0;
    assign hi_hit    = 1'b0;
  end

  always_comb begin
    irq_nxt = (|(cause_lo & mask_lo_q)) | hi_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_nxt;
    end
  end

  assign mask_lo = mask_lo_q;
  assign irq     = irq_q;

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int unsigned       NUM_PINS    = 32,
  parameter int unsigned       PIN_GROUP   = 8,
  parameter int unsigned       SUMMARY_LSB = 24,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] LO_VALID    = LO_VALID_DEF,
  parameter logic [WORD_W-1:0] HI_VALID    = HI_VALID_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W-1:0]     unit_req_lo,
  input  logic [WORD_W-1:0]     unit_req_hi,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic [NUM_CPUS-1:0]   cpu_irq
);

  localparam int unsigned       NUM_GROUPS = NUM_PINS / PIN_GROUP;
  localparam logic [WORD_W-1:0] SUM_FIELD  = WORD_W'(((64'd1 << NUM_GROUPS) - 64'd1) << SUMMARY_LSB);

  logic rst_sync_n;

  irq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // write decode
  reg_addr_e addr_e;
  logic      wr_pin_cause;
  logic      wr_pin_mask;
  logic [NUM_CPUS-1:0] wr_cpu_lo;
  logic [NUM_CPUS-1:0] wr_cpu_hi;

  assign addr_e = reg_addr_e'(reg_addr);

  always_comb begin
    wr_pin_cause = reg_wr && (addr_e == RA_PIN_CAUSE);
    wr_pin_mask  = reg_wr && (addr_e == RA_PIN_MASK);
    wr_cpu_lo    = '0;
    wr_cpu_hi    = '0;
    wr_cpu_lo[0] = reg_wr && (addr_e == RA_CPU0_LO);
    wr_cpu_hi[0] = reg_wr && (addr_e == RA_CPU0_HI);
    wr_cpu_lo[1] = reg_wr && (addr_e == RA_CPU1_LO);
  end

  // pin bank
  logic [NUM_PINS-1:0]   pin_cause;
  logic [NUM_PINS-1:0]   pin_mask;
  logic [NUM_PINS-1:0]   pin_prev;
  logic [NUM_GROUPS-1:0] pin_summary;

  irq_pin_bank #(
    .NUM_PINS    (NUM_PINS),
    .PIN_GROUP   (PIN_GROUP),
    .NUM_GROUPS  (NUM_GROUPS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_pin_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_in     (pin_in),
    .wr_cause   (wr_pin_cause),
    .wr_mask    (wr_pin_mask),
    .wdata      (reg_wdata[NUM_PINS-1:0]),
    .cause      (pin_cause),
    .mask       (pin_mask),
    .prev_level (pin_prev),
    .summary    (pin_summary)
  );

  // main cause words, live and filtered
  logic [WORD_W-1:0] lo_cause;
  logic [WORD_W-1:0] hi_cause;

  always_comb begin
    lo_cause = unit_req_lo & LO_VALID;
    hi_cause = (unit_req_hi & HI_VALID & ~SUM_FIELD)
             | (WORD_W'(pin_summary) << SUMMARY_LSB);
  end

  // per-CPU enables and registered outputs
  logic [WORD_W-1:0] cpu_mask_lo [NUM_CPUS];
  logic [WORD_W-1:0] cpu_mask_hi [NUM_CPUS];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_port #(
      .WORD_W (WORD_W),
      .HAS_HI (c == 0)
    ) i_cpu_port (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_lo    (wr_cpu_lo[c]),
      .wr_hi    (wr_cpu_hi[c]),
      .wdata    (reg_wdata),
      .cause_lo (lo_cause),
      .cause_hi (hi_cause),
      .mask_lo  (cpu_mask_lo[c]),
      .mask_hi  (cpu_mask_hi[c]),
      .irq      (cpu_irq[c])
    );
  end

  // read mux, zero wait states
  always_comb begin
    unique case (addr_e)
      RA_MAIN_LO:   reg_rdata = lo_cause;
      RA_MAIN_HI:   reg_rdata = hi_cause;
      RA_PIN_CAUSE: reg_rdata = WORD_W'(pin_cause);
      RA_PIN_MASK:  reg_rdata = WORD_W'(pin_mask);
      RA_CPU0_LO:   reg_rdata = cpu_mask_lo[0];
      RA_CPU0_HI:   reg_rdata = cpu_mask_hi[0];
      RA_CPU1_LO:   reg_rdata = cpu_mask_lo[1];
      default:      reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int unsigned       NUM_PINS    = 32,
  parameter int unsigned       NUM_GROUPS  = 4,
  parameter int unsigned       SUMMARY_LSB = 24,
  parameter logic [WORD_W-1:0] LO_VALID    = LO_VALID_DEF
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0]     reg_wdata,
  input logic [WORD_W-1:0]     reg_rdata,
  input logic [NUM_CPUS-1:0]   cpu_irq,
  input logic [NUM_PINS-1:0]   pin_cause,
  input logic [NUM_PINS-1:0]   pin_prev,
  input logic [NUM_PINS-1:0]   pin_mask,
  input logic [WORD_W-1:0]     lo_cause,
  input logic [WORD_W-1:0]     hi_cause,
  input logic [WORD_W-1:0]     m0_lo,
  input logic [WORD_W-1:0]     m0_hi,
  input logic [WORD_W-1:0]     m1_lo
);

  logic pin_wr;
  assign pin_wr = reg_wr && (reg_addr == RA_PIN_CAUSE);

  // R2: invalid low positions never read back as one
  p_lo_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_MAIN_LO) |-> ((reg_rdata & ~LO_VALID) == '0));

  // R7: with every pin disabled the summary field stays clear
  p_summary_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mask == '0) |-> (hi_cause[SUMMARY_LSB +: NUM_GROUPS] == '0));

  // R4: without a write to the pin cause word no set bit falls
  p_pin_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_wr |=> ((pin_cause & $past(pin_cause)) == $past(pin_cause)));

  // R5: a zero-written bit with no edge pending ends clear
  p_w0c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_wr |=> ((pin_cause & ~$past(reg_wdata[NUM_PINS-1:0]) & $past(pin_prev)) == '0));

  // R8: CPU0 stays quiet while both of its enables are zero
  p_cpu0_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((m0_lo == '0) && (m0_hi == '0)) |=> !cpu_irq[0]);

  // R9: CPU1 stays quiet when no enabled low cause is present
  p_cpu1_lo_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_cause & m1_lo) == '0) |=> !cpu_irq[1]);

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
  .NUM_PINS    (NUM_PINS),
  .NUM_GROUPS  (NUM_GROUPS),
  .SUMMARY_LSB (SUMMARY_LSB),
  .LO_VALID    (LO_VALID)
) i_irq_cascade_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cpu_irq   (cpu_irq),
  .pin_cause (pin_cause),
  .pin_prev  (pin_prev),
  .pin_mask  (pin_mask),
  .lo_cause  (lo_cause),
  .hi_cause  (hi_cause),
  .m0_lo     (cpu_mask_lo[0]),
  .m0_hi     (cpu_mask_hi[0]),
  .m1_lo     (cpu_mask_lo[1])
);

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
  import irq_cascade_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] unit_req_lo;
  logic [31:0] unit_req_hi;
  logic [31:0] pin_in;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  cpu_irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 0;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_req_lo (unit_req_lo),
    .unit_req_hi (unit_req_hi),
    .pin_in      (pin_in),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cpu_irq     (cpu_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, $sformatf("read addr %0d", a), reg_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    step(1);
    reg_wr    = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "cpu_irq after reset", {30'd0, cpu_irq}, 32'd0);
    rd_chk("R1", RA_PIN_CAUSE, 32'd0);
    rd_chk("R1", RA_PIN_MASK,  32'd0);
    rd_chk("R1", RA_CPU0_LO,   32'd0);
    rd_chk("R1", RA_CPU0_HI,   32'd0);
    rd_chk("R1", RA_CPU1_LO,   32'd0);
  endtask

  task automatic t_main_cause;
    unit_req_lo = 32'hFFFF_FFFF;
    unit_req_hi = 32'hFFFF_FFFF;
    rd_chk("R2", RA_MAIN_LO, 32'h3DFF_FFFE);
    rd_chk("R3", RA_MAIN_HI, 32'h1000_03F7);
    unit_req_lo = 32'd0;
    unit_req_hi = 32'd0;
    rd_chk("R2", RA_MAIN_LO, 32'd0);
    rd_chk("R2", RA_MAIN_HI, 32'd0);
    step(1);
  endtask

  task automatic t_pin_latch;
    pin_in = 32'h0000_0020;
    step(2);
    rd_chk("R4", RA_PIN_CAUSE, 32'd0);
    step(1);
    rd_chk("R4", RA_PIN_CAUSE, 32'h0000_0020);
    pin_in = 32'd0;
    step(4);
    rd_chk("R4", RA_PIN_CAUSE, 32'h0000_0020);
    step(1);
  endtask

  task automatic t_summary;
    rd_chk("R7", RA_MAIN_HI, 32'd0);
    step(1);
    wr(RA_PIN_MASK, 32'h0000_0020);
    rd_chk("R7", RA_MAIN_HI, 32'h0100_0000);
    step(1);
    pin_in = 32'h8002_0000;
    step(3);
    wr(RA_PIN_MASK, 32'h8002_0020);
    rd_chk("R3", RA_MAIN_HI, 32'h0D00_0000);
    rd_chk("R10", RA_PIN_MASK, 32'h8002_0020);
    step(1);
    wr(RA_PIN_MASK, 32'd0);
    unit_req_hi = 32'h0F00_0000;
    rd_chk("R3", RA_MAIN_HI, 32'd0);
    unit_req_hi = 32'd0;
    step(1);
  endtask

  task automatic t_w0c;
    wr(RA_PIN_CAUSE, ~32'h0002_0000);
    rd_chk("R5", RA_PIN_CAUSE, 32'h8000_0020);
    step(1);
    wr(RA_PIN_CAUSE, 32'hFFFF_FFFF);
    rd_chk("R5", RA_PIN_CAUSE, 32'h8000_0020);
    step(1);
    wr(RA_PIN_CAUSE, 32'd0);
    rd_chk("R5", RA_PIN_CAUSE, 32'd0);
    step(1);
    pin_in = 32'd0;
    wr(RA_MAIN_LO, 32'hFFFF_FFFF);
    wr(RA_SPARE, 32'hFFFF_FFFF);
    rd_chk("R10", RA_MAIN_LO, 32'd0);
    rd_chk("R10", RA_SPARE, 32'd0);
    step(3);
  endtask

  task automatic t_set_wins;
    pin_in = 32'h0002_0000;
    step(3);
    pin_in = 32'h0002_0200;
    step(2);
    wr(RA_PIN_CAUSE, 32'd0);
    rd_chk("R6", RA_PIN_CAUSE, 32'h0000_0200);
    step(1);
    wr(RA_PIN_CAUSE, 32'd0);
    rd_chk("R4", RA_PIN_CAUSE, 32'd0);
    pin_in = 32'd0;
    step(3);
  endtask

  task automatic t_cpu0;
    wr(RA_CPU0_LO, 32'h0000_0008);
    unit_req_lo = 32'h0000_0008;
    #1;
    check("R8", "cpu0 before edge", {31'd0, cpu_irq[0]}, 32'd0);
    step(1);
    check("R8", "cpu0 one edge later", {31'd0, cpu_irq[0]}, 32'd1);
    unit_req_lo = 32'd0;
    #1;
    check("R8", "cpu0 holds until edge", {31'd0, cpu_irq[0]}, 32'd1);
    step(1);
    check("R8", "cpu0 drops", {31'd0, cpu_irq[0]}, 32'd0);
    wr(RA_CPU0_LO, 32'hFFFF_FFFF);
    unit_req_lo = ~32'h3DFF_FFFE;
    step(2);
    check("R2", "invalid low bits raise nothing", {30'd0, cpu_irq}, 32'd0);
    unit_req_lo = 32'd0;
    wr(RA_CPU0_LO, 32'd0);
    wr(RA_CPU0_HI, 32'h0400_0000);
    wr(RA_PIN_MASK, 32'h0002_0000);
    pin_in = 32'h0002_0000;
    step(4);
    check("R8", "cpu0 through pin summary", {30'd0, cpu_irq}, 32'd1);
    wr(RA_PIN_CAUSE, ~32'h0002_0000);
    step(1);
    check("R8", "cpu0 after pin clear", {30'd0, cpu_irq}, 32'd0);
    pin_in = 32'd0;
    wr(RA_CPU0_HI, 32'd0);
  endtask

  task automatic t_cpu1;
    wr(RA_CPU1_LO, 32'h1000_0000);
    unit_req_lo = 32'h1000_0000;
    step(1);
    check("R9", "doorbell to cpu1 only", {30'd0, cpu_irq}, 32'd2);
    unit_req_lo = 32'h0000_0008;
    step(1);
    check("R9", "other low source blocked", {30'd0, cpu_irq}, 32'd0);
    unit_req_lo = 32'd0;
    wr(RA_CPU1_LO, 32'hFFFF_FFFF);
    unit_req_hi = 32'h1000_03F7;
    step(2);
    check("R9", "high word never at cpu1", {30'd0, cpu_irq}, 32'd0);
    rd_chk("R10", RA_CPU1_LO, 32'hFFFF_FFFF);
    unit_req_hi = 32'd0;
    step(1);
  endtask

  initial begin
    rst_n       = 1'b0;
    unit_req_lo = '0;
    unit_req_hi = '0;
    pin_in      = '0;
    reg_wr      = 1'b0;
    reg_addr    = '0;
    reg_wdata   = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_main_cause();
    t_pin_latch();
    t_summary();
    t_w0c();
    t_set_wins();
    t_cpu0();
    t_cpu1();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule